// File: doc/BRIEF.md
# Per-Drive Positioning Status Tracker

This block sits beside a floppy controller's command sequencer and stores the status of positioning commands (seek and recalibrate) until software collects it. There is one slot for each drive. A slot records whether status is waiting, and holds two result bytes: the status-0 byte and the present cylinder. The block also drives the per-drive busy bits of the controller's main status register. When a positioning command on a drive completes, that drive's busy bit is set. The bit stays set until a sense-interrupt command collects the drive's status.

The sequencer reports each finished command as a completion event that carries the drive number, the 5-bit opcode and the two result bytes. It raises a sense request when software issues a sense-interrupt-status command, and it raises a controller-reset event when the adapter leaves its reset state. The block answers each sense request one cycle later. The answer is either the two stored bytes of the lowest-numbered waiting drive, together with a strobe that clears the interrupt line, or an invalid-command marker. A controller reset fills every slot with a synthesized status, so that the usual four sense commands after a reset each find a record.

Top module: `sis_slot_tracker`

## Requirements
- R1: A completion event whose opcode is 5'h0F (seek) or 5'h07 (recalibrate) stores its two result bytes in the slot of its drive, marks that slot waiting, and sets bit d of `drive_busy` on the next cycle, where d is the drive number.
- R2: A completion event with any other opcode empties the slot of its drive and leaves that drive's `drive_busy` bit unchanged.
- R3: A sense request produces a `rsp_valid` pulse exactly one cycle long, one cycle later. The request serves the waiting slot with the lowest drive number.
- R4: Serving a slot returns its status-0 byte on `rsp_st0` and its cylinder on `rsp_cyl` with `rsp_invalid` low. The same cycle pulses `int_clear`. The slot becomes empty, and the drive's `drive_busy` bit reads 0 from that cycle on.
- R5: A sense request that finds no waiting slot returns `rsp_invalid` high, `rsp_st0` = 8'h80 and `rsp_cyl` = 0, and does not pulse `int_clear`.
- R6: A controller-reset event marks all slots waiting, with status byte 8'hC0 + i and cylinder 0 for drive i, and clears every `drive_busy` bit. A completion event or sense request in the same cycle is ignored, and no response is produced for it.
- R7: When a completion event and a sense request arrive in the same cycle, the completion is applied first, and the sense request sees the updated slots.
- R8: While `rst` is high, all slots are emptied and `drive_busy`, `rsp_valid`, `rsp_invalid`, `int_clear`, `rsp_st0` and `rsp_cyl` are 0.
- R9: Between responses, `rsp_invalid`, `rsp_st0` and `rsp_cyl` keep the values of the last response.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cmp_valid | input | 1 | Completion event strobe |
| cmp_drive | input | 2 | Drive of the completed command |
| cmp_opcode | input | 5 | Opcode of the completed command |
| cmp_st0 | input | 8 | Status-0 result byte of the completed command |
| cmp_cyl | input | 8 | Present-cylinder result byte of the completed command |
| sense_req | input | 1 | Sense-interrupt-status request strobe |
| ctl_reset | input | 1 | Controller-reset event strobe |
| rsp_valid | output | 1 | Response present (one cycle) |
| rsp_invalid | output | 1 | Response is the invalid-command marker |
| rsp_st0 | output | 8 | First response byte |
| rsp_cyl | output | 8 | Second response byte |
| int_clear | output | 1 | Strobe that clears the interrupt line when a slot is served |
| drive_busy | output | 4 | Per-drive busy bits, bit i for drive i |

## Verification
The assertions check several relations on every cycle: busy bits after positioning and non-positioning completions, the form of an invalid response, the pairing of the clear strobe with a served response, the one-cycle response latency, and the idle state after a controller reset. Some behaviour can only be shown by the bench's scenarios, where a reference model follows the slot contents. This covers which drive is served when several are waiting, the exact bytes returned, the preloaded status after a controller reset, and the ordering of a completion and a sense request in the same cycle.

// File: rtl/sis_pkg.sv
package sis_pkg;

    localparam int BYTE_W = 8;
    localparam int OP_W   = 5;

    localparam logic [OP_W-1:0]   OP_SEEK        = 5'h0F;
    localparam logic [OP_W-1:0]   OP_RECAL       = 5'h07;
    localparam logic [BYTE_W-1:0] INVALID_CODE   = 8'h80;
    localparam logic [BYTE_W-1:0] RESET_ST0_BASE = 8'hC0;

    typedef struct packed {
        logic              full;
        logic [BYTE_W-1:0] st0;
        logic [BYTE_W-1:0] cyl;
    } slot_t;

    typedef struct packed {
        logic              valid;
        logic              invalid;
        logic              clr;
        logic [BYTE_W-1:0] st0;
        logic [BYTE_W-1:0] cyl;
    } resp_t;

    function automatic logic is_positioning(input logic [OP_W-1:0] op);
        return (op == OP_SEEK) || (op == OP_RECAL);
    endfunction

endpackage

// File: rtl/sis_slot_entry.sv
module sis_slot_entry
    import sis_pkg::*;
#(
    parameter int IDX = 0
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              ctl_reset,
    input  logic              fill,
    input  logic              drop,
    input  logic              serve,
    input  logic [BYTE_W-1:0] new_st0,
    input  logic [BYTE_W-1:0] new_cyl,
    output slot_t             view,
    output logic              busy
);

    slot_t cur;

    // Slot contents with this cycle's completion already applied.
    always_comb begin
        view = cur;
        if (fill) begin
            view.full = 1'b1;
            view.st0  = new_st0;
            view.cyl  = new_cyl;
        end else if (drop) begin
            view.full = 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cur  <= '0;
            busy <= 1'b0;
        end else if (ctl_reset) begin
            cur.full <= 1'b1;
            cur.st0  <= RESET_ST0_BASE + BYTE_W'(IDX);
            cur.cyl  <= '0;
            busy     <= 1'b0;
        end else begin
            cur <= view;
            if (serve) begin
                cur.full <= 1'b0;
            end
            if (serve) begin
                busy <= 1'b0;
            end else if (fill) begin
                busy <= 1'b1;
            end
        end
    end

endmodule

// File: rtl/sis_lowest_pick.sv
module sis_lowest_pick #(
    parameter int N = 4
) (
    input  logic [N-1:0] req,
    output logic [N-1:0] grant,
    output logic         any
);

    logic [N:0] seen;

    assign seen[0] = 1'b0;

    for (genvar i = 0; i < N; i++) begin : g_chain
        assign seen[i+1] = seen[i] | req[i];
        assign grant[i]  = req[i] & ~seen[i];
    end

    assign any = seen[N];

endmodule

// File: rtl/sis_resp_reg.sv
module sis_resp_reg
    import sis_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              take,
    input  logic              hit,
    input  logic [BYTE_W-1:0] sel_st0,
    input  logic [BYTE_W-1:0] sel_cyl,
    output resp_t             q
);

    always_ff @(posedge clk) begin
        if (rst) begin
            q <= '0;
        end else begin
            q.valid <= take;
            q.clr   <= take & hit;
            if (take) begin
                q.invalid <= ~hit;
                q.st0     <= hit ? sel_st0 : INVALID_CODE;
                q.cyl     <= hit ? sel_cyl : '0;
            end
        end
    end

endmodule

// File: rtl/sis_slot_tracker.sv
module sis_slot_tracker
    import sis_pkg::*;
#(
    parameter int NUM_DRIVES = 4,
    localparam int DRV_W     = (NUM_DRIVES > 1) ? $clog2(NUM_DRIVES) : 1
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  cmp_valid,
    input  logic [DRV_W-1:0]      cmp_drive,
    input  logic [OP_W-1:0]       cmp_opcode,
    input  logic [BYTE_W-1:0]     cmp_st0,
    input  logic [BYTE_W-1:0]     cmp_cyl,
    input  logic                  sense_req,
    input  logic                  ctl_reset,
    output logic                  rsp_valid,
    output logic                  rsp_invalid,
    output logic [BYTE_W-1:0]     rsp_st0,
    output logic [BYTE_W-1:0]     rsp_cyl,
    output logic                  int_clear,
    output logic [NUM_DRIVES-1:0] drive_busy
);

    logic                  cmp_pos;
    logic                  take;
    logic                  hit;
    logic [NUM_DRIVES-1:0] fill;
    logic [NUM_DRIVES-1:0] drop;
    logic [NUM_DRIVES-1:0] waiting;
    logic [NUM_DRIVES-1:0] grant;
    logic [NUM_DRIVES-1:0] serve;
    slot_t                 view [NUM_DRIVES];
    logic [BYTE_W-1:0]     sel_st0;
    logic [BYTE_W-1:0]     sel_cyl;
    resp_t                 resp;

    assign cmp_pos = is_positioning(cmp_opcode);
    assign take    = sense_req & ~ctl_reset;

    for (genvar i = 0; i < NUM_DRIVES; i++) begin : g_slot
        assign fill[i]    = cmp_valid && (cmp_drive == DRV_W'(i)) && cmp_pos;
        assign drop[i]    = cmp_valid && (cmp_drive == DRV_W'(i)) && !cmp_pos;
        assign waiting[i] = view[i].full;
        assign serve[i]   = grant[i] & take;

        sis_slot_entry #(.IDX(i)) u_entry (
            .clk       (clk),
            .rst       (rst),
            .ctl_reset (ctl_reset),
            .fill      (fill[i]),
            .drop      (drop[i]),
            .serve     (serve[i]),
            .new_st0   (cmp_st0),
            .new_cyl   (cmp_cyl),
            .view      (view[i]),
            .busy      (drive_busy[i])
        );
    end

    sis_lowest_pick #(.N(NUM_DRIVES)) u_pick (
        .req   (waiting),
        .grant (grant),
        .any   (hit)
    );

    always_comb begin
        sel_st0 = '0;
        sel_cyl = '0;
        for (int i = 0; i < NUM_DRIVES; i++) begin
            sel_st0 |= view[i].st0 & {BYTE_W{grant[i]}};
            sel_cyl |= view[i].cyl & {BYTE_W{grant[i]}};
        end
    end

    sis_resp_reg u_resp (
        .clk     (clk),
        .rst     (rst),
        .take    (take),
        .hit     (hit),
        .sel_st0 (sel_st0),
        .sel_cyl (sel_cyl),
        .q       (resp)
    );

    assign rsp_valid   = resp.valid;
    assign rsp_invalid = resp.invalid;
    assign rsp_st0     = resp.st0;
    assign rsp_cyl     = resp.cyl;
    assign int_clear   = resp.clr;

endmodule

// File: rtl/sis_slot_tracker_chk.sv
module sis_slot_tracker_chk
    import sis_pkg::*;
#(
    parameter int NUM_DRIVES = 4,
    localparam int DRV_W     = (NUM_DRIVES > 1) ? $clog2(NUM_DRIVES) : 1
) (
    input logic                  clk,
    input logic                  rst,
    input logic                  cmp_valid,
    input logic [DRV_W-1:0]      cmp_drive,
    input logic [OP_W-1:0]       cmp_opcode,
    input logic                  sense_req,
    input logic                  ctl_reset,
    input logic                  rsp_valid,
    input logic                  rsp_invalid,
    input logic [BYTE_W-1:0]     rsp_st0,
    input logic [BYTE_W-1:0]     rsp_cyl,
    input logic                  int_clear,
    input logic [NUM_DRIVES-1:0] drive_busy
);

    logic pos_op;
    assign pos_op = (cmp_opcode == 5'h0F) || (cmp_opcode == 5'h07);

    AST_BUSY_AFTER_POSITIONING: assert property (@(posedge clk) disable iff (rst)
        (cmp_valid && pos_op && !sense_req && !ctl_reset) |=> drive_busy[$past(cmp_drive)]) // R1
        else $error("positioning completion did not set busy");

    AST_BUSY_KEPT_OTHER_OP: assert property (@(posedge clk) disable iff (rst)
        (cmp_valid && !pos_op && !sense_req && !ctl_reset)
        |=> drive_busy[$past(cmp_drive)] == $past(drive_busy[cmp_drive])) // R2
        else $error("non-positioning completion changed busy");

    AST_RESP_ONE_CYCLE_AFTER_REQ: assert property (@(posedge clk) disable iff (rst)
        rsp_valid |-> ($past(sense_req) && !$past(ctl_reset))) // R3
        else $error("response without request");

    AST_CLEAR_ONLY_WHEN_SERVED: assert property (@(posedge clk) disable iff (rst)
        int_clear |-> (rsp_valid && !rsp_invalid)) // R4
        else $error("interrupt clear without served slot");

    AST_INVALID_MARKER: assert property (@(posedge clk) disable iff (rst)
        (rsp_valid && rsp_invalid) |-> (rsp_st0 == 8'h80 && rsp_cyl == 8'h00 && !int_clear)) // R5
        else $error("invalid response malformed");

    AST_CTL_RESET_IDLE: assert property (@(posedge clk) disable iff (rst)
        ctl_reset |=> (drive_busy == '0 && !rsp_valid && !int_clear)) // R6
        else $error("controller reset left busy or response");

    AST_RESULT_HELD: assert property (@(posedge clk) disable iff (rst)
        (!$past(sense_req) && !$past(rst)) |-> ($stable(rsp_st0) && $stable(rsp_cyl) && $stable(rsp_invalid))) // R9
        else $error("response bytes changed without request");

endmodule

bind sis_slot_tracker sis_slot_tracker_chk #(.NUM_DRIVES(NUM_DRIVES)) chk_i (
    .clk         (clk),
    .rst         (rst),
    .cmp_valid   (cmp_valid),
    .cmp_drive   (cmp_drive),
    .cmp_opcode  (cmp_opcode),
    .sense_req   (sense_req),
    .ctl_reset   (ctl_reset),
    .rsp_valid   (rsp_valid),
    .rsp_invalid (rsp_invalid),
    .rsp_st0     (rsp_st0),
    .rsp_cyl     (rsp_cyl),
    .int_clear   (int_clear),
    .drive_busy  (drive_busy)
);

// File: tb/sis_slot_tracker_tb_top.sv
module sis_slot_tracker_tb_top;

    localparam int ND = 4;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       cmp_valid = 1'b0;
    logic [1:0] cmp_drive = '0;
    logic [4:0] cmp_opcode = '0;
    logic [7:0] cmp_st0 = '0;
    logic [7:0] cmp_cyl = '0;
    logic       sense_req = 1'b0;
    logic       ctl_reset = 1'b0;
    logic       rsp_valid;
    logic       rsp_invalid;
    logic [7:0] rsp_st0;
    logic [7:0] rsp_cyl;
    logic       int_clear;
    logic [3:0] drive_busy;

    int    checks = 0;
    int    errors = 0;
    string tag = "R8";
    bit    done = 1'b0;

    always #5 clk = ~clk;

    sis_slot_tracker #(.NUM_DRIVES(ND)) dut_i (
        .clk(clk), .rst(rst), .cmp_valid(cmp_valid), .cmp_drive(cmp_drive),
        .cmp_opcode(cmp_opcode), .cmp_st0(cmp_st0), .cmp_cyl(cmp_cyl),
        .sense_req(sense_req), .ctl_reset(ctl_reset), .rsp_valid(rsp_valid),
        .rsp_invalid(rsp_invalid), .rsp_st0(rsp_st0), .rsp_cyl(rsp_cyl),
        .int_clear(int_clear), .drive_busy(drive_busy)
    );

    // Behavioural reference model
    bit       m_full [ND];
    int       m_b0 [ND];
    int       m_b1 [ND];
    bit [3:0] m_busy = '0;
    bit       m_valid = 0, m_inv = 0, m_clr = 0;
    int       m_st0 = 0, m_cyl = 0;

    always @(posedge clk) begin
        int found;
        if (rst) begin
            for (int i = 0; i < ND; i++) begin
                m_full[i] = 0; m_b0[i] = 0; m_b1[i] = 0;
            end
            m_busy = '0; m_valid = 0; m_inv = 0; m_clr = 0; m_st0 = 0; m_cyl = 0;
        end else if (ctl_reset) begin
            for (int i = 0; i < ND; i++) begin
                m_full[i] = 1; m_b0[i] = 'hC0 + i; m_b1[i] = 0;
            end
            m_busy = '0; m_valid = 0; m_clr = 0;
        end else begin
            if (cmp_valid) begin
                if (cmp_opcode == 5'h0F || cmp_opcode == 5'h07) begin
                    m_full[cmp_drive] = 1;
                    m_b0[cmp_drive] = cmp_st0;
                    m_b1[cmp_drive] = cmp_cyl;
                    m_busy[cmp_drive] = 1;
                end else begin
                    m_full[cmp_drive] = 0;
                end
            end
            m_valid = 0; m_clr = 0;
            if (sense_req) begin
                found = -1;
                for (int i = ND - 1; i >= 0; i--) if (m_full[i]) found = i;
                m_valid = 1;
                if (found >= 0) begin
                    m_inv = 0; m_st0 = m_b0[found]; m_cyl = m_b1[found];
                    m_full[found] = 0; m_busy[found] = 0; m_clr = 1;
                end else begin
                    m_inv = 1; m_st0 = 'h80; m_cyl = 0;
                end
            end
        end
    end

    task automatic check(input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
        end
    endtask

    always @(negedge clk) begin
        if (!done) begin
            check("drive_busy", drive_busy, m_busy);
            check("rsp_valid", rsp_valid, m_valid);
            check("int_clear", int_clear, m_clr);
            check("rsp_invalid", rsp_invalid, m_inv);
            check("rsp_st0", rsp_st0, m_st0);
            check("rsp_cyl", rsp_cyl, m_cyl);
        end
    end

    task automatic cyc(input bit cv, input int drv, input int op, input int s0, input int cy,
                       input bit sr, input bit cr);
        cmp_valid = cv; cmp_drive = 2'(drv); cmp_opcode = 5'(op);
        cmp_st0 = 8'(s0); cmp_cyl = 8'(cy); sense_req = sr; ctl_reset = cr;
        @(negedge clk);
    endtask

    task automatic idle();
        cyc(0, 0, 0, 0, 0, 0, 0);
    endtask

    initial begin
        // R8: reset state
        tag = "R8";
        repeat (3) @(negedge clk);
        rst = 1'b0;
        idle();
        // R5: sense with nothing waiting
        tag = "R5";
        cyc(0, 0, 0, 0, 0, 1, 0); idle();
        // R1 / R3 / R4: two positioning completions, lowest drive first
        tag = "R1";
        cyc(1, 2, 'h0F, 'h22, 'h10, 0, 0);
        cyc(1, 1, 'h07, 'h21, 'h00, 0, 0); idle();
        tag = "R3";
        cyc(0, 0, 0, 0, 0, 1, 0); idle();
        tag = "R4";
        cyc(0, 0, 0, 0, 0, 1, 0); idle();
        tag = "R5";
        cyc(0, 0, 0, 0, 0, 1, 0); idle();
        // R2: other opcode empties the slot but keeps busy
        tag = "R2";
        cyc(1, 3, 'h0F, 'h23, 'h40, 0, 0);
        cyc(1, 3, 'h06, 'h00, 'h00, 0, 0); idle();
        cyc(0, 0, 0, 0, 0, 1, 0); idle();
        // R6: controller reset with a sense and completion in the same cycle
        tag = "R6";
        cyc(1, 0, 'h0F, 'h55, 'h66, 1, 1); idle();
        for (int k = 0; k < 5; k++) begin
            cyc(0, 0, 0, 0, 0, 1, 0);
        end
        idle();
        // R7: completion and sense in the same cycle
        tag = "R7";
        cyc(1, 0, 'h0F, 'h20, 'h33, 1, 0); idle();
        cyc(0, 0, 0, 0, 0, 0, 1);
        cyc(1, 0, 'h05, 0, 0, 1, 0); idle();
        // R9: outputs held between responses
        tag = "R9";
        repeat (4) idle();
        // Mixed traffic
        tag = "R3";
        for (int k = 0; k < 600; k++) begin
            int sel;
            int opc;
            sel = $urandom_range(0, 3);
            opc = (sel == 0) ? 'h0F : (sel == 1) ? 'h07 : (sel == 2) ? 'h06 : 'h05;
            cyc(($urandom_range(0, 2) == 0), $urandom_range(0, 3), opc,
                $urandom_range(0, 255), $urandom_range(0, 255),
                ($urandom_range(0, 2) == 0), ($urandom_range(0, 60) == 0));
        end
        idle();
        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            checks++;
            errors++;
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule